// File: doc/BRIEF.md
# Byte-Lane Bit Gather, Compare and Parity Unit

This block is a purely combinational execution slice for a 64-bit integer datapath. It takes two source operands, `rs_i` and `rb_i`, and a 3-bit operation select. It returns one 64-bit result in the same cycle. It offers three byte-oriented operations:

- **Bit gather.** Each byte of `rs_i` acts as an index into `rb_i`. The eight chosen bits are packed into the low byte of the result.
- **Lane compare.** Each result byte becomes a mask that says whether that lane of the two operands matches.
- **Low-bit parity.** The least significant bit of every byte of `rs_i` is folded by XOR. The fold covers either the whole doubleword or each 32-bit half separately.

The block drives no condition or status flag. Its only effect is the result word. The surrounding pipeline registers the result and writes it back.

Top module: `byte_lane_logic`

## Requirements
- R1: With select 3'd0 (gather), the most significant byte of `rs_i` (bits 63:56) is index 0. The bit it chooses lands in result bit 7. Each following byte fills the next lower result bit, and the least significant byte fills result bit 0.
- R2: A gather index value n in the range 0..63 chooses bit (63 - n) of `rb_i`. Bits are counted from the most significant end, so index 0 is the MSB.
- R3: A gather index whose full 8-bit unsigned value is 64..255 contributes a 0 bit, whatever `rb_i` holds.
- R4: With select 3'd0, result bits 63:8 are always zero.
- R5: With select 3'd1 (compare), each result byte k (bits 8k+7:8k) is 8'hFF when byte k of `rs_i` equals byte k of `rb_i`, and 8'h00 otherwise.
- R6: With select 3'd2 (doubleword parity), result bit 0 is the XOR of `rs_i` bits 0, 8, 16, 24, 32, 40, 48 and 56. All other result bits are zero.
- R7: With select 3'd3 (word parity):
  - Result bit 32 is the XOR of `rs_i` bits 32, 40, 48 and 56.
  - Result bit 0 is the XOR of `rs_i` bits 0, 8, 16 and 24.
  - All other result bits are zero.
- R8: Selects 3'd4 to 3'd7 give an all-zero result, whatever the operands are.
- R9: The result depends only on the present inputs. The same operands and select give the same result whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_i | input | 64 | First source operand: gather indices, compare operand, parity source |
| rb_i | input | 64 | Second source operand: gather bit source, compare operand |
| op_i | input | 3 | Operation select: 0 gather, 1 compare, 2 doubleword parity, 3 word parity |
| res_o | output | 64 | Result word |

## Verification
The gather, compare and parity datapaths all read the same operand bytes at once. The select alone decides which one reaches the result, so a leak from an unselected path is the main hazard. The bench provokes this by holding one operand pair while stepping the select through every code on consecutive cycles, both in directed runs and in random runs. Each cycle is judged against a reference model in the bench, and every bit outside the chosen operation's defined field must stay zero.

// File: rtl/bll_pkg.sv
package bll_pkg;

  typedef enum logic [2:0] {
    OP_GATHER = 3'd0,
    OP_LANECMP = 3'd1,
    OP_PAR_DW = 3'd2,
    OP_PAR_WD = 3'd3
  } bll_op_e;

  localparam int BYTE_W = 8;

  // XOR-fold of the least significant bit of every byte in a vector
  function automatic logic low_bit_fold(input logic [63:0] v, input int first_lane,
                                        input int n_lanes);
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k >= first_lane && k < first_lane + n_lanes) acc = acc ^ v[k*BYTE_W];
    end
    return acc;
  endfunction

endpackage

// File: rtl/bll_gather.sv
module bll_gather #(
  parameter int XLEN = 64,
  localparam int LANES = XLEN / 8,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rb_i,
  output logic [LANES-1:0] gathered_o,
  output logic [LANES-1:0] idx_in_range_o
);

  // rb re-ordered so that position n holds the bit numbered n from the MSB
  logic [XLEN-1:0] rb_msb_first;

  for (genvar b = 0; b < XLEN; b++) begin : g_rev
    assign rb_msb_first[b] = rb_i[XLEN-1-b];
  end

  // lane q counts from the most significant byte of rs
  for (genvar q = 0; q < LANES; q++) begin : g_lane
    logic [7:0]      idx;
    logic [IDXW-1:0] pos;
    assign idx = rs_i[XLEN-1-8*q -: 8];
    assign pos = idx[IDXW-1:0];
    assign idx_in_range_o[q] = (int'(idx) < XLEN);
    assign gathered_o[LANES-1-q] = idx_in_range_o[q] & rb_msb_first[pos];
  end

endmodule

// File: rtl/bll_lanecmp.sv
module bll_lanecmp #(
  parameter int XLEN = 64,
  localparam int LANES = XLEN / 8
) (
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rb_i,
  output logic [LANES-1:0] lane_eq_o,
  output logic [XLEN-1:0]  mask_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_eq_o[k] = (rs_i[8*k +: 8] == rb_i[8*k +: 8]);
    assign mask_o[8*k +: 8] = {8{lane_eq_o[k]}};
  end

endmodule

// File: rtl/bll_parity.sv
module bll_parity #(
  parameter int XLEN = 64,
  localparam int LANES = XLEN / 8,
  localparam int HALF = LANES / 2
) (
  input  logic [XLEN-1:0] rs_i,
  output logic            par_lo_o,
  output logic            par_hi_o
);

  logic [XLEN-1:0] src;
  assign src = rs_i;

  always_comb begin
    par_lo_o = bll_pkg::low_bit_fold(64'(src), 0, HALF);
    par_hi_o = bll_pkg::low_bit_fold(64'(src), HALF, HALF);
  end

endmodule

// File: rtl/byte_lane_logic.sv
module byte_lane_logic #(
  parameter int XLEN = 64,
  localparam int LANES = XLEN / 8
) (
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rb_i,
  input  logic [2:0]      op_i,
  output logic [XLEN-1:0] res_o
);
  import bll_pkg::*;

  logic [LANES-1:0] gathered;
  logic [LANES-1:0] perm_hit;
  logic [LANES-1:0] lane_eq;
  logic [XLEN-1:0]  cmp_mask;
  logic             par_lo;
  logic             par_hi;

  bll_gather #(.XLEN(XLEN)) u_gather (
    .rs_i(rs_i), .rb_i(rb_i), .gathered_o(gathered), .idx_in_range_o(perm_hit)
  );

  bll_lanecmp #(.XLEN(XLEN)) u_cmp (
    .rs_i(rs_i), .rb_i(rb_i), .lane_eq_o(lane_eq), .mask_o(cmp_mask)
  );

  bll_parity #(.XLEN(XLEN)) u_par (
    .rs_i(rs_i), .par_lo_o(par_lo), .par_hi_o(par_hi)
  );

  always_comb begin
    res_o = '0;
    case (op_i)
      OP_GATHER:  res_o[LANES-1:0] = gathered;
      OP_LANECMP: res_o = cmp_mask;
      OP_PAR_DW:  res_o[0] = par_lo ^ par_hi;
      OP_PAR_WD: begin
        res_o[0]      = par_lo;
        res_o[XLEN/2] = par_hi;
      end
      default:    res_o = '0;
    endcase
  end

endmodule

// File: rtl/byte_lane_logic_chk.sv
module byte_lane_logic_chk #(
  parameter int XLEN = 64,
  localparam int LANES = XLEN / 8
) (
  input logic [XLEN-1:0]  rs_i,
  input logic [XLEN-1:0]  rb_i,
  input logic [2:0]       op_i,
  input logic [XLEN-1:0]  res_o,
  input logic [LANES-1:0] perm_hit,
  input logic [LANES-1:0] lane_eq,
  input logic             par_lo,
  input logic             par_hi
);

  always_comb begin
    if (op_i == 3'd0) begin
      // R4
      gather_upper_zero_chk: assert (res_o[XLEN-1:LANES] == '0);
      for (int q = 0; q < LANES; q++) begin
        // R3
        gather_range_zero_chk: assert (perm_hit[q] || !res_o[LANES-1-q]);
      end
    end
    if (op_i == 3'd1) begin
      for (int k = 0; k < LANES; k++) begin
        // R5
        lane_mask_chk: assert (res_o[8*k +: 8] == {8{lane_eq[k]}});
      end
      // R5
      equal_all_ones_chk: assert ((rs_i != rb_i) || (&res_o));
    end
    if (op_i == 3'd2) begin
      // R6
      dw_parity_chk: assert (res_o == {{(XLEN-1){1'b0}}, par_lo ^ par_hi});
    end
    if (op_i == 3'd3) begin
      // R7
      wd_parity_chk: assert (res_o[0] == par_lo && res_o[XLEN/2] == par_hi &&
                             $countones(res_o) == 32'(par_lo) + 32'(par_hi));
    end
    if (op_i[2]) begin
      // R8
      unused_sel_zero_chk: assert (res_o == '0);
    end
  end

endmodule

bind byte_lane_logic byte_lane_logic_chk #(.XLEN(XLEN)) u_chk (
  .rs_i(rs_i), .rb_i(rb_i), .op_i(op_i), .res_o(res_o),
  .perm_hit(perm_hit), .lane_eq(lane_eq), .par_lo(par_lo), .par_hi(par_hi)
);

// File: tb/test_byte_lane_logic.sv
module test_byte_lane_logic;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rs, rb, res;
  logic [2:0]  op;
  int          n_vec = 0;
  int          n_bad = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  byte_lane_logic i_byte_lane_logic (.rs_i(rs), .rb_i(rb), .op_i(op), .res_o(res));

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [2:0] sel);
    logic [63:0] r;
    int idx, cnt_all, cnt_lo, cnt_hi;
    r = 0;
    case (sel)
      3'd0: for (int i = 0; i < 8; i++) begin
              idx = int'((a >> (56 - 8*i)) & 64'hFF);
              if (idx < 64 && b[63-idx]) r = r | (64'd1 << (7 - i));
            end
      3'd1: for (int i = 0; i < 8; i++)
              if (a[8*i +: 8] == b[8*i +: 8]) r[8*i +: 8] = 8'hFF;
      3'd2, 3'd3: begin
        cnt_lo = 0; cnt_hi = 0;
        for (int i = 0; i < 4; i++) cnt_lo += int'(a[8*i]);
        for (int i = 4; i < 8; i++) cnt_hi += int'(a[8*i]);
        cnt_all = cnt_lo + cnt_hi;
        if (sel == 3'd2) r[0] = cnt_all[0];
        else begin r[0] = cnt_lo[0]; r[32] = cnt_hi[0]; end
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] sel);
    case (sel)
      3'd0: return "R1 R2 R3 R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [2:0] sel,
                       input string tag);
    logic [63:0] exp;
    @(posedge clk);
    rs = a; rb = b; op = sel;
    @(negedge clk);
    exp = model(a, b, sel);
    n_vec++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d rs=%h rb=%h actual=%h expected=%h", tag, sel, a, b, res, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
  endtask

  initial begin
    rs = 0; rb = 0; op = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands
    apply(64'd0, 64'd0, 3'd0, "R1 idle");
    // R1 R2: index 0 in top byte selects rb MSB into result bit 7
    apply(64'h0001_0203_0405_0607, 64'h8000_0000_0000_0000, 3'd0, "R1");
    apply(64'h3F3F_3F3F_3F3F_3F3F, 64'h0000_0000_0000_0001, 3'd0, "R2");
    apply(64'h0000_0000_0000_003F, 64'h0000_0000_0000_0001, 3'd0, "R2");
    // R3: out-of-range indices 64..255 give 0
    apply(64'h407F_FF80_003F_4101, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R3");
    apply(64'h4040_4040_C0C0_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R3");
    // R4
    apply(64'h0001_0203_0405_0607, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, "R4");
    // R5
    apply(64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 3'd1, "R5");
    apply(64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 3'd1, "R5");
    apply(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 3'd1, "R5");
    // R6
    apply(64'h0100_0000_0000_0000, 64'd0, 3'd2, "R6");
    apply(64'h0101_0101_0101_0101, 64'd0, 3'd2, "R6");
    apply(64'hFEFE_FEFE_FEFE_FEFE, 64'd0, 3'd2, "R6");
    // R7
    apply(64'h0100_0000_0000_0001, 64'd0, 3'd3, "R7");
    apply(64'h0001_0000_0001_0100, 64'd0, 3'd3, "R7");
    apply(64'h0000_0000_0100_0000, 64'd0, 3'd3, "R7");
    // R8
    for (int s = 4; s < 8; s++)
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'(s), "R8");
    // R9: same operands under every select, back to back, twice
    for (int rep = 0; rep < 2; rep++)
      for (int s = 0; s < 8; s++)
        apply(64'h0105_3F40_0101_0F00, 64'h0105_3F41_0101_0F00, 3'(s), "R9");
    // random operands, each pair stepped through all selects
    for (int n = 0; n < 1500; n++) begin
      logic [63:0] a, b;
      step_lfsr(); a = lfsr;
      step_lfsr(); b = (n % 3 == 0) ? (a ^ (lfsr & 64'h00FF_0000_FF00_00FF)) : lfsr;
      if (n % 4 == 0) a = a & 64'h3F3F_3F3F_7F7F_3F3F;
      for (int s = 0; s < 8; s++) apply(a, b, 3'(s), tag_of(3'(s)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule